// File: doc/BRIEF.md
# Wakeup Edge Detection Controller

This block watches one group of input pins and raises a wakeup interrupt when a pin shows the edge that software has chosen for it. Each pin can be set to catch a rising edge, a falling edge, or any change. Pins come from outside the clock domain, so each one passes through a synchronizer first. Edge detection compares the synchronized level with the level from the previous cycle.

A detected edge sets a sticky status bit for that pin. The bit stays set until software writes a one to it. A per-pin enable decides whether a set status bit drives the shared interrupt output. A build-time parameter can drop the enable register. In that build every pin counts as enabled, and accesses to that register index change nothing.

Software reaches four byte-wide registers over a small register bus. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address.

Top module: `wake_edge_unit`

## Requirements
- R1: After reset, registers 0 (edge mode), 1 (status), 2 (enable) and 3 (both-edge) all read 0x00, and `wakeIrq` is low.
- R2: With its both-edge bit clear, a pin whose edge-mode bit (register 0) is 0 sets its status bit only on a rising edge. A pin whose edge-mode bit is 1 sets it only on a falling edge.
- R3: A pin whose bit in register 3 is 1 sets its status bit on both rising and falling edges, whatever its edge-mode bit holds.
- R4: A write to register 1 clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R5: Status bits latch whether or not the pin is enabled. `wakeIrq` is high exactly when some pin has both its status bit and its effective enable bit set.
- R6: If a pin's edge is detected in the same cycle that software writes a 1 to clear that pin's status bit, the status bit ends up set.
- R7: A pin change that arrives before clock edge k appears in the status register after clock edge k+2, and not earlier.
- R8: With `HAS_ENABLE` = 0, writes to register 2 are ignored, register 2 reads 0xFF, and any set status bit drives `wakeIrq`.
- R9: Registers 0, 2 and 3 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Asynchronous wakeup pins |
| regAddr | input | 2 | Register index: 0 edge mode, 1 status, 2 enable, 3 both-edge |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | NUM_PINS | Write data, one bit per pin |
| regRdData | output | NUM_PINS | Read data for the register at `regAddr` |
| wakeIrq | output | 1 | Wakeup interrupt, OR over pins of status AND enable |

## Verification
A wrong edge decode or a corrupted mode register shows up as a wrong status byte three cycles after the pin change. The bench reads that byte back at exactly that cycle, and one cycle earlier to pin down the latency. A status bit that is lost, cleared by mistake or never cleared shows up at the next status read and on `wakeIrq` in the same cycle. A faulty enable shows up only on `wakeIrq`, because status latches either way. The vector table walks each mode against rising, falling and mixed pin changes. Directed cases cover a clear that lands on the same cycle as a set, and the build without the enable register.

// File: rtl/wake_edge_pkg.sv
package wake_edge_pkg;

  typedef enum logic [1:0] {
    IDX_MODE   = 2'd0,
    IDX_STATUS = 2'd1,
    IDX_ENABLE = 2'd2,
    IDX_BOTH   = 2'd3
  } regIdx_t;

  typedef struct packed {
    logic wrMode;
    logic clrStatus;
    logic wrEnable;
    logic wrBoth;
  } regStrobe_t;

endpackage

// File: rtl/wake_edge_decode.sv
module wake_edge_decode
  import wake_edge_pkg::*;
#(
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  output regStrobe_t strobe
);

  regIdx_t idx;

  always_comb begin
    idx = regIdx_t'(regAddr);
    strobe = '0;
    if (regWrEn) begin
      unique case (idx)
        IDX_MODE:   strobe.wrMode    = 1'b1;
        IDX_STATUS: strobe.clrStatus = 1'b1;
        IDX_ENABLE: strobe.wrEnable  = HAS_ENABLE;
        IDX_BOTH:   strobe.wrBoth    = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

  // R9: at most one register is written per cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R8: the missing enable register never receives a write
  a_r8_no_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    (!HAS_ENABLE && regWrEn && regAddr == 2'd2) |-> !strobe.wrEnable);

endmodule

// File: rtl/wake_edge_datapath.sv
module wake_edge_datapath
  import wake_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_ENABLE  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  regStrobe_t          strobe,
  input  logic [1:0]          regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                wakeIrq
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] modeQ, bothQ, statusQ, effEn;
  logic [NUM_PINS-1:0] riseHit, fallHit, edgeHit, clrMask;

  // synchronizer chain and previous-level register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign riseHit = syncQ[LAST] & ~prevQ;
  assign fallHit = ~syncQ[LAST] & prevQ;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      if (bothQ[p])      edgeHit[p] = riseHit[p] | fallHit[p];
      else if (modeQ[p]) edgeHit[p] = fallHit[p];
      else               edgeHit[p] = riseHit[p];
    end
  end

  assign clrMask = strobe.clrStatus ? regWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= '0;
      bothQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strobe.wrMode) modeQ <= regWrData;
      if (strobe.wrBoth) bothQ <= regWrData;
      statusQ <= (statusQ & ~clrMask) | edgeHit;
    end
  end

  if (HAS_ENABLE) begin : g_en
    logic [NUM_PINS-1:0] enableQ;
    always_ff @(posedge clk) begin
      if (!rstN)                enableQ <= '0;
      else if (strobe.wrEnable) enableQ <= regWrData;
    end
    assign effEn = enableQ;
  end else begin : g_noen
    assign effEn = '1;
  end

  always_comb begin
    unique case (regIdx_t'(regAddr))
      IDX_MODE:   regRdData = modeQ;
      IDX_STATUS: regRdData = statusQ;
      IDX_ENABLE: regRdData = effEn;
      IDX_BOTH:   regRdData = bothQ;
      default:    regRdData = '0;
    endcase
  end

  assign wakeIrq = |(statusQ & effEn);

  // R4: a status bit falls only when software wrote a one to it
  a_r4_clear_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~statusQ & ~$past(clrMask)) == '0));

  // R2: a status bit rises only on a detected edge
  a_r2_set_only_by_edge: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(edgeHit)) == '0));

  // R6: a detected edge always leaves its status bit set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> (($past(edgeHit) & ~statusQ) == '0));

  // R5: the interrupt needs at least one latched status bit
  a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (statusQ != '0));

endmodule

// File: rtl/wake_edge_unit.sv
module wake_edge_unit
  import wake_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_ENABLE  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                wakeIrq
);

  regStrobe_t strobe;

  wake_edge_decode #(.HAS_ENABLE(HAS_ENABLE)) decode_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  wake_edge_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES),
    .HAS_ENABLE  (HAS_ENABLE)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .wakeIrq   (wakeIrq)
  );

endmodule

// File: tb/wake_edge_unit_tb_top.sv
module wake_edge_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinIn2 = '0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData, regRdData2;
  logic       wakeIrq, wakeIrq2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_edge_unit dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .wakeIrq(wakeIrq)
  );

  wake_edge_unit #(.HAS_ENABLE(1'b0)) dutNoEn_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn2), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData2), .wakeIrq(wakeIrq2)
  );

  // {mode, both, pins, expected status}; pins start at 0x00
  localparam logic [31:0] VEC [10] = '{
    32'h00_00_FF_FF, 32'h00_00_00_00, 32'hFF_00_0F_00, 32'hFF_00_00_0F,
    32'h0F_00_FF_F0, 32'h0F_00_00_0F, 32'hAA_0F_33_13, 32'hAA_0F_00_23,
    32'h00_FF_5A_5A, 32'hFF_FF_A5_FF
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d, output logic [7:0] d2);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData; d2 = regRdData2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v, v2);
      chk("R1 reset register", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, wakeIrq}, 8'h00);

    // R9: readback
    regWrite(2'd0, 8'h3C); regWrite(2'd2, 8'hA5); regWrite(2'd3, 8'h96);
    regRead(2'd0, v, v2); chk("R9 mode readback", v, 8'h3C);
    regRead(2'd2, v, v2); chk("R9 enable readback", v, 8'hA5);
    chk("R8 enable write ignored", v2, 8'hFF);
    regRead(2'd3, v, v2); chk("R9 both readback", v, 8'h96);

    // R2/R3: vector table, all pins enabled
    regWrite(2'd2, 8'hFF);
    for (int i = 0; i < 10; i++) begin
      regWrite(2'd0, VEC[i][31:24]);
      regWrite(2'd3, VEC[i][23:16]);
      regWrite(2'd1, 8'hFF);
      @(negedge clk); pinIn = VEC[i][15:8];
      repeat (3) @(posedge clk);
      regRead(2'd1, v, v2);
      chk((VEC[i][23:16] != 0) ? "R3 both-edge vector" : "R2 edge vector", v, VEC[i][7:0]);
      chk("R5 irq on vector", {7'd0, wakeIrq}, {7'd0, VEC[i][7:0] != 0});
    end

    // settle: rising mode, pins low, status clear
    regWrite(2'd0, 8'h00); regWrite(2'd3, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    repeat (4) @(posedge clk);
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, v, v2); chk("R4 clear all", v, 8'h00);

    // R7: latency
    @(negedge clk); pinIn = 8'h01;
    repeat (2) @(posedge clk);
    regRead(2'd1, v, v2); chk("R7 not yet after two edges", v, 8'h00);
    @(posedge clk);
    regRead(2'd1, v, v2); chk("R7 set after third edge", v, 8'h01);

    // R4: partial clear
    @(negedge clk); pinIn = 8'hFF;
    repeat (3) @(posedge clk);
    regWrite(2'd1, 8'h0F);
    regRead(2'd1, v, v2); chk("R4 partial clear", v, 8'hF0);

    // R5: status latches while disabled; irq follows enable
    regWrite(2'd1, 8'hFF);
    regWrite(2'd2, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    regWrite(2'd3, 8'h10);
    @(negedge clk); pinIn = 8'h10;
    repeat (3) @(posedge clk);
    regRead(2'd1, v, v2); chk("R5 status while disabled", v, 8'h10);
    chk("R5 irq low while disabled", {7'd0, wakeIrq}, 8'h00);
    regWrite(2'd2, 8'h10);
    #1; chk("R5 irq after enable", {7'd0, wakeIrq}, 8'h01);
    regWrite(2'd2, 8'hEF);
    #1; chk("R5 irq with other pins enabled", {7'd0, wakeIrq}, 8'h00);

    // R6: set wins over same-cycle clear
    regWrite(2'd3, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    repeat (4) @(posedge clk);
    regWrite(2'd1, 8'hFF);
    @(negedge clk); pinIn = 8'h02;
    repeat (4) @(posedge clk);
    regRead(2'd1, v, v2); chk("R6 setup", v, 8'h02);
    @(negedge clk); pinIn = 8'h03;
    @(negedge clk);
    @(negedge clk);
    regAddr = 2'd1; regWrData = 8'h03; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    regRead(2'd1, v, v2); chk("R6 set wins", v, 8'h01);

    // R8: no enable register, irq from any status
    regWrite(2'd2, 8'h00);
    regRead(2'd2, v, v2); chk("R8 enable reads all ones", v2, 8'hFF);
    regWrite(2'd1, 8'hFF);
    @(negedge clk); pinIn2 = 8'h80;
    repeat (3) @(posedge clk);
    regRead(2'd1, v, v2); chk("R8 status", v2, 8'h80);
    chk("R8 irq always enabled", {7'd0, wakeIrq2}, 8'h01);

    finishRun();
  end

endmodule